// File: doc/BRIEF.md
# Dual Comparator Output Conditioner

This block is the digital back end for a pair of analog comparators. Each comparator hands over a raw one-bit decision that is asynchronous to the system clock. The block synchronizes it and can clean it with a sampling noise filter whose sample rate is selectable. The cleaned value drives three things: a readable status flag, a pin output with selectable polarity and a gate, and a one-clock interrupt pulse on the chosen transition (rising only, falling only, or either).

Software sets each channel up through three byte-wide registers on a plain write/read port. The mode register holds the enables and the status flags. The filter register holds the sample rate and edge choice. The output register holds the pin and interrupt controls. Each channel owns one nibble of every register: channel 0 uses bits 3:0 and channel 1 uses bits 7:4. The analog comparators, reference generation and input selection sit outside the block.

Top module: `cmpc_top`

## Requirements
- R1: After reset, all three registers read 0x00, and every pin output and interrupt line is 0.
- R2: Register map, with n = 4 times the channel number. Address 0: enable at bit n, read-only status flag at bit n+3, other bits read 0. Address 1: sample rate at bits n+1:n, polarity at bit n+2, both-edges at bit n+3. Address 2: interrupt enable at bit n, pin enable at bit n+1, pin invert at bit n+2, bit n+3 reads 0. Address 3 reads 0x00.
- R3: The status flag reads 0 while its channel is disabled. While the channel is enabled, it equals the conditioned comparator value.
- R4: With sample rate 00 (no filter), a change of the raw input first shows on the status flag after the third rising clock edge.
- R5: With sample rate 01 (every clock), the conditioned value changes only after three consecutive samples agree. A raw pulse two clocks wide is rejected, and a held change shows after the fifth rising edge.
- R6: With sample rate 10 the filter samples once every 8 clocks, and with 11 once every 32 clocks. A held change therefore takes at least 16 clocks (rate 10) or 64 clocks (rate 11) to be accepted, and it is accepted within 40 or 130 clocks.
- R7: With both-edges = 1, every transition of the conditioned value is a qualifying edge. With both-edges = 0, polarity 0 selects rising edges only and polarity 1 selects falling edges only.
- R8: Each qualifying edge raises exactly one interrupt pulse, one clock wide. No pulse is produced while the interrupt enable is 0 or the channel is disabled.
- R9: The pin output equals status flag XOR pin invert when the pin enable is 1, and it is 0 when the pin enable is 0.
- R10: Enabling a channel whose input is already high produces no interrupt.
- R11: The two channels are independent. The same input event on both channels gives each channel's result according to its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 2 | Raw comparator decisions, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pin_out | output | 2 | Conditioned pin outputs |
| irq | output | 2 | One-clock interrupt pulses |

## Verification
A wrong filter history or a wrong sample counter shows up as a status flag that flips too early, flips too late, or accepts a short glitch. The R4 to R6 windows bound this to a few clocks for the fast rates and to under 130 clocks for the slowest. A stale previous-value register shows up as an interrupt that is missing, doubled or unexpected. The scoreboard catches it at the edge where it happens, or catches the missing event once the run drains. A corrupted configuration bit is visible at once on the register read port and on the pin output.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

  typedef enum logic [1:0] {
    FS_OFF    = 2'b00,
    FS_EVERY  = 2'b01,
    FS_DIV_LO = 2'b10,
    FS_DIV_HI = 2'b11
  } fsel_e;

  typedef struct packed {
    logic  en;
    fsel_e fsel;
    logic  pol;
    logic  both;
    logic  ie;
    logic  oe;
    logic  op;
  } chan_cfg_t;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_FILT = 2'd1;
  localparam logic [1:0] ADDR_OUTC = 2'd2;

endpackage

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cmpc_sampler.sv
module cmpc_sampler
  import cmpc_pkg::*;
#(
  parameter int DIV_LO = 8,
  parameter int DIV_HI = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  fsel_e fsel,
  output logic  strobe
);
  localparam int CW = $clog2(DIV_HI);
  localparam int LW = $clog2(DIV_LO);

  logic [CW-1:0] cnt_q, cnt_d;
  fsel_e         fsel_q;
  logic          restart;

  // A new rate setting restarts the prescaler from zero.
  assign restart = (fsel != fsel_q);

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + CW'(1);
  end

  always_comb begin
    unique case (fsel)
      FS_OFF:    strobe = 1'b0;
      FS_EVERY:  strobe = 1'b1;
      FS_DIV_LO: strobe = (cnt_q[LW-1:0] == {LW{1'b1}});
      FS_DIV_HI: strobe = (cnt_q == {CW{1'b1}});
      default:   strobe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fsel_q <= FS_OFF;
    end else begin
      cnt_q  <= cnt_d;
      fsel_q <= fsel;
    end
  end
endmodule

// File: rtl/cmpc_channel.sv
module cmpc_channel
  import cmpc_pkg::*;
#(
  parameter int DIV_LO      = 8,
  parameter int DIV_HI      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw,
  input  chan_cfg_t cfg,
  output logic      mon,
  output logic      pin,
  output logic      irq
);
  logic       sync_v;
  logic       strobe;
  logic [1:0] hist_q, hist_d;
  logic       filt_q, filt_d;
  logic       prev_q, prev_d;
  logic       rise, fall, hit;

  cmpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(sync_v)
  );

  cmpc_sampler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_smp (
    .clk(clk), .rst_n(rst_n), .fsel(cfg.fsel), .strobe(strobe)
  );

  // Filter next state. While disabled or unfiltered, the state follows
  // the synchronized input so that enabling never creates a false edge.
  always_comb begin
    hist_d = hist_q;
    filt_d = filt_q;
    if (!cfg.en || cfg.fsel == FS_OFF) begin
      hist_d = {sync_v, sync_v};
      filt_d = sync_v;
    end else if (strobe) begin
      hist_d = {hist_q[0], sync_v};
      if (sync_v == hist_q[0] && sync_v == hist_q[1]) filt_d = sync_v;
    end
  end

  always_comb begin
    prev_d = filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      filt_q <= filt_d;
      prev_q <= prev_d;
    end
  end

  assign rise = filt_q & ~prev_q;
  assign fall = ~filt_q & prev_q;

  always_comb begin
    if (cfg.both)     hit = rise | fall;
    else if (cfg.pol) hit = fall;
    else              hit = rise;
  end

  assign mon = cfg.en & filt_q;
  assign pin = cfg.oe & (mon ^ cfg.op);
  assign irq = cfg.en & cfg.ie & hit;
endmodule

// File: rtl/cmpc_regs.sv
module cmpc_regs
  import cmpc_pkg::*;
#(
  parameter int NCH = 2,
  parameter int RW  = 4 * NCH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [RW-1:0]        wdata,
  input  logic [NCH-1:0]       mon,
  output chan_cfg_t [NCH-1:0]  cfg,
  output logic [RW-1:0]        rdata
);
  logic [NCH-1:0] en_q, en_d;
  logic [RW-1:0]  filt_q, filt_d;
  logic [RW-1:0]  outc_q, outc_d;
  logic [RW-1:0]  outc_mask;
  logic           we_mode, we_filt, we_outc;

  assign we_mode = we && (addr == ADDR_MODE);
  assign we_filt = we && (addr == ADDR_FILT);
  assign we_outc = we && (addr == ADDR_OUTC);

  always_comb begin
    outc_mask = '0;
    for (int i = 0; i < NCH; i++) outc_mask[4*i +: 3] = 3'b111;
  end

  always_comb begin
    en_d   = en_q;
    filt_d = filt_q;
    outc_d = outc_q;
    if (we_mode) begin
      for (int i = 0; i < NCH; i++) en_d[i] = wdata[4*i];
    end
    if (we_filt) filt_d = wdata;
    if (we_outc) outc_d = wdata & outc_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      filt_q <= '0;
      outc_q <= '0;
    end else begin
      en_q   <= en_d;
      filt_q <= filt_d;
      outc_q <= outc_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cfg
    assign cfg[g].en   = en_q[g];
    assign cfg[g].fsel = fsel_e'(filt_q[4*g +: 2]);
    assign cfg[g].pol  = filt_q[4*g + 2];
    assign cfg[g].both = filt_q[4*g + 3];
    assign cfg[g].ie   = outc_q[4*g];
    assign cfg[g].oe   = outc_q[4*g + 1];
    assign cfg[g].op   = outc_q[4*g + 2];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_MODE: begin
        for (int i = 0; i < NCH; i++) begin
          rdata[4*i]     = en_q[i];
          rdata[4*i + 3] = mon[i];
        end
      end
      ADDR_FILT: rdata = filt_q;
      ADDR_OUTC: rdata = outc_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmpc_top.sv
module cmpc_top
  import cmpc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int DIV_LO      = 8,
  parameter int DIV_HI      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RW          = 4 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmp_raw,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [RW-1:0]  reg_wdata,
  output logic [RW-1:0]  reg_rdata,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] irq
);
  logic [1:0]            rs_q;
  logic                  rst_int_n;
  chan_cfg_t [NCH-1:0]   cfg;
  logic [NCH-1:0]        mon_v, en_v, ie_v, oe_v, pol_v, both_v;

  // Reset asserts at once, releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  cmpc_regs #(.NCH(NCH), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .mon(mon_v), .cfg(cfg), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cmpc_channel #(
      .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SYNC_STAGES(SYNC_STAGES)
    ) u_ch (
      .clk(clk), .rst_n(rst_int_n), .raw(cmp_raw[g]), .cfg(cfg[g]),
      .mon(mon_v[g]), .pin(pin_out[g]), .irq(irq[g])
    );
    assign en_v[g]   = cfg[g].en;
    assign ie_v[g]   = cfg[g].ie;
    assign oe_v[g]   = cfg[g].oe;
    assign pol_v[g]  = cfg[g].pol;
    assign both_v[g] = cfg[g].both;
  end
endmodule

// File: rtl/cmpc_checker.sv
module cmpc_checker #(
  parameter int NCH = 2,
  parameter int RW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] en_v,
  input logic [NCH-1:0] ie_v,
  input logic [NCH-1:0] oe_v,
  input logic [NCH-1:0] pol_v,
  input logic [NCH-1:0] both_v,
  input logic [NCH-1:0] mon_v,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] pin_out,
  input logic [1:0]     reg_addr,
  input logic [RW-1:0]  reg_rdata
);
  a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r3_flag_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_v[i] |-> !mon_v[i]);
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (en_v[i] && ie_v[i]));
    a_r9_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_v[i] |-> !pin_out[i]);
    a_r7_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !both_v[i] && !pol_v[i]) |-> mon_v[i]);
    a_r7_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !both_v[i] && pol_v[i]) |-> !mon_v[i]);
  end
endmodule

bind cmpc_top cmpc_checker #(.NCH(NCH), .RW(RW)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_v(en_v), .ie_v(ie_v), .oe_v(oe_v),
  .pol_v(pol_v), .both_v(both_v), .mon_v(mon_v), .irq(irq),
  .pin_out(pin_out), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_cmpc_top.sv
module test_cmpc_top;
  logic       clk;
  logic       rst_n;
  logic [1:0] cmp_raw;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [1:0] pin_out;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 0;

  cmpc_top i_cmpc_top (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_out(pin_out), .irq(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  // Driver: change one raw input at a negedge, push the expected interrupt.
  task automatic drive(input int ch, input logic v, input bit expect_irq);
    @(negedge clk);
    cmp_raw[ch] = v;
    if (expect_irq) exp_q.push_back(ch);
  endtask

  // Monitor: every observed interrupt pulse must match the next expected one.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 2; c++) begin
        if (irq[c]) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected interrupt actual=ch%0d expected=none", c);
          end else begin
            int e;
            e = exp_q.pop_front();
            if (e != c) begin
              errors++;
              $display("FAIL R7 interrupt channel actual=%0d expected=%0d", c, e);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cmp_raw = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    tick(4);
    rst_n = 1;
    tick(4);

    // R1 reset state
    rd_check("R1 mode", 2'd0, 8'h00);
    rd_check("R1 filter", 2'd1, 8'h00);
    rd_check("R1 output", 2'd2, 8'h00);
    check("R1 pins", pin_out, 2'b00);
    check("R1 irq", irq, 2'b00);

    // R2 register map
    wr(2'd1, 8'hFF); rd_check("R2 filter rw", 2'd1, 8'hFF);
    wr(2'd2, 8'hFF); rd_check("R2 output rw", 2'd2, 8'h77);
    wr(2'd0, 8'hFF); rd_check("R2 mode rw", 2'd0, 8'h11);
    rd_check("R2 hole", 2'd3, 8'h00);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R3 flag stays 0 while disabled
    drive(0, 1'b1, 0);
    tick(6);
    rd_check("R3 disabled flag", 2'd0, 8'h00);

    // R10 enable with input already high: no interrupt
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h01);
    tick(5);
    check("R10 no irq on enable", irq, 2'b00);
    rd_check("R3 enabled flag", 2'd0, 8'h09);

    // R7 rising mode ignores falling edge
    drive(0, 1'b0, 0);
    tick(3);
    check("R7 falling ignored", irq[0], 1'b0);
    rd_check("R3 flag follows low", 2'd0, 8'h01);
    tick(2);

    // R4 unfiltered latency, R8 single pulse
    drive(0, 1'b1, 1);
    tick(1); rd_check("R4 flag after 1 edge", 2'd0, 8'h01);
    tick(1); rd_check("R4 flag after 2 edges", 2'd0, 8'h01);
    tick(1); rd_check("R4 flag after 3 edges", 2'd0, 8'h09);
    check("R8 pulse present", irq[0], 1'b1);
    tick(1); check("R8 pulse one clock", irq[0], 1'b0);
    tick(2);

    // R7 falling-only mode
    wr(2'd1, 8'h04);
    drive(0, 1'b0, 1); tick(4);
    drive(0, 1'b1, 0); tick(3);
    check("R7 rising ignored in falling mode", irq[0], 1'b0);
    tick(2);

    // R7 both-edges mode
    wr(2'd1, 8'h08);
    drive(0, 1'b0, 1); tick(4);
    drive(0, 1'b1, 1); tick(4);

    // R8 interrupt enable gating
    wr(2'd2, 8'h00);
    drive(0, 1'b0, 0); tick(3);
    check("R8 ie=0 suppresses", irq[0], 1'b0);
    tick(2);
    drive(0, 1'b1, 0); tick(5);

    // R9 pin output: enable, invert, gate
    wr(2'd2, 8'h03); check("R9 pin normal", pin_out[0], 1'b1);
    wr(2'd2, 8'h07); check("R9 pin inverted", pin_out[0], 1'b0);
    wr(2'd2, 8'h05); check("R9 pin gated low", pin_out[0], 1'b0);
    wr(2'd2, 8'h07);
    drive(0, 1'b0, 1); tick(3);
    check("R9 inverted low input", pin_out[0], 1'b1);
    tick(2);

    // R5 every-clock filter: glitch rejection and acceptance latency
    wr(2'd1, 8'h09);
    tick(3);
    drive(0, 1'b1, 0); tick(2); cmp_raw[0] = 0;
    tick(8);
    rd_check("R5 glitch rejected", 2'd0, 8'h01);
    drive(0, 1'b1, 1);
    tick(4); rd_check("R5 not yet after 4 edges", 2'd0, 8'h01);
    tick(1); rd_check("R5 accepted after 5 edges", 2'd0, 8'h09);
    tick(3);

    // R6 divide-by-8 sampling
    wr(2'd1, 8'h0A);
    drive(0, 1'b0, 1);
    tick(12); rd_check("R6 div8 too early", 2'd0, 8'h09);
    tick(28); rd_check("R6 div8 accepted", 2'd0, 8'h01);

    // R6 divide-by-32 sampling
    wr(2'd1, 8'h0B);
    drive(0, 1'b1, 1);
    tick(60); rd_check("R6 div32 too early", 2'd0, 8'h01);
    tick(70); rd_check("R6 div32 accepted", 2'd0, 8'h09);

    // R11 independent channels
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h11);
    wr(2'd0, 8'h11);
    tick(4);
    drive(1, 1'b1, 1); tick(3);
    check("R11 ch1 rises alone", irq, 2'b10);
    rd_check("R11 both flags", 2'd0, 8'h99);
    tick(2);
    @(negedge clk); cmp_raw = 2'b00; exp_q.push_back(1);
    tick(3);
    check("R11 same event, own edge modes", irq, 2'b10);
    tick(3);

    // R3/R8 disabling channel 1 clears its flag and blocks interrupts
    wr(2'd0, 8'h01);
    rd_check("R3 ch1 disabled flag", 2'd0, 8'h01);
    drive(1, 1'b1, 0); tick(3);
    check("R8 disabled channel silent", irq[1], 1'b0);
    tick(10);

    check("R8 no missing interrupts", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule